// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block drives the SCL line of an I2C master from a fast system clock. It supports two bus speeds. Standard speed is 100 kHz, with equal low and high phases. Fast speed is 400 kHz, where the low phase lasts two units and the high phase one unit. Every count comes from the `SYS_CLK_HZ` parameter at elaboration time, so the block has no run-time divider registers.

The output `scl_pull_o` tells the open-drain pad to pull SCL low. After the block releases the line, it watches the sensed level `scl_sense_i`. The high-phase count does not start until the line actually reads high. This covers a slow rising edge and a target that holds SCL low (clock stretching). If the line stays low longer than a rise-time limit derived from the clock frequency in MHz, a sticky timeout flag is set.

A byte engine uses two one-cycle strobes. `shift_stb_o` marks the first cycle of each low phase, when SDA may change. `sample_stb_o` marks the middle of each high phase, when SDA is sampled. The speed selection is captured only while `enable_i` is low. SDA handling and bus arbitration are not part of this block.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset the block is idle. `scl_pull_o`=0 (line released), `fast_mode_o`=0, and both strobes and `stretch_timeout_o` are 0.
- R2: At standard speed the low phase lasts `SYS_CLK_HZ/200000` cycles with `scl_pull_o`=1. The high-phase count has the same length.
- R3: At fast speed the unit is `SYS_CLK_HZ/1200000` cycles. The low phase lasts 2 units and the high-phase count lasts 1 unit.
- R4: The rise limit is `MHz+1` cycles at standard speed and `300*MHz/1000+1` cycles at fast speed, where MHz = `SYS_CLK_HZ/1000000`. `stretch_timeout_o` rises when the released line has read low for more than the limit. It then stays set until `enable_i` falls.
- R5: The high-phase count starts only after `scl_sense_i` reads 1. Each cycle the released line reads 0 extends the released time by one cycle.
- R6: `fast_req_i` is captured into `fast_mode_o` only in cycles where `enable_i`=0. While the block is enabled, changes to `fast_req_i` have no effect.
- R7: If `SYS_CLK_HZ` is below 4 MHz, a fast request falls back to standard speed: `fast_mode_o` stays 0 and standard timing is used.
- R8: `shift_stb_o` is high for exactly the first cycle of each low phase. `sample_stb_o` is high for one cycle, at high-phase count index `high/2`, where index 0 is the cycle after the line is seen high.
- R9: One cycle after `enable_i` falls, the line is released and the timeout flag is cleared. A new enable always starts with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run the SCL clock |
| fast_req_i | input | 1 | Request fast speed; captured only while disabled |
| scl_sense_i | input | 1 | Sensed SCL pad level |
| scl_pull_o | output | 1 | 1 = pull SCL low, 0 = release |
| shift_stb_o | output | 1 | One-cycle strobe at the start of the low phase |
| sample_stb_o | output | 1 | One-cycle strobe at the middle of the high phase |
| stretch_timeout_o | output | 1 | Sticky flag: released line stayed low beyond the rise limit |
| fast_mode_o | output | 1 | Currently selected speed (1 = fast) |

## Verification
The assertions check rules that must hold on every cycle. The mode must stay frozen while the block is enabled. The strobes must never coincide, each strobe must fall in its own phase, the line must be released one cycle after disable, and the timeout flag must stay set while enabled. The exact low and high lengths, the sample-strobe position, the stretch extension and the timeout threshold need more than one cycle to see. The bench's directed scenarios measure these against counts it computes itself. The slow-clock fallback is also shown only by the bench, using a second instance.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_mode_latch.sv
module scl_mode_latch #(
  parameter bit FAST_OK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic fast_req_i,
  output logic fast_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fast_q <= 1'b0;
    else if (!enable_i)  fast_q <= fast_req_i & FAST_OK;
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i && $past(enable_i) |-> $stable(fast_q)); // R6
endmodule

// File: rtl/scl_timing_sel.sv
module scl_timing_sel #(
  parameter int SYS_CLK_HZ = 8_000_000,
  parameter int CW         = 8
) (
  input  logic          fast_i,
  output logic [CW-1:0] low_len_o,
  output logic [CW-1:0] high_len_o,
  output logic [CW-1:0] rise_lim_o
);
  localparam int MHZ       = SYS_CLK_HZ / 1_000_000;
  localparam int STD_HALF  = SYS_CLK_HZ / 200_000;
  localparam int STD_RISE  = MHZ + 1;
  localparam int FAST_UNIT = SYS_CLK_HZ / 1_200_000;
  localparam int FAST_RISE = (300 * MHZ) / 1000 + 1;

  generate
    if (MHZ >= 4) begin : g_two_speed
      always_comb begin
        if (fast_i) begin
          low_len_o  = CW'(2 * FAST_UNIT);
          high_len_o = CW'(FAST_UNIT);
          rise_lim_o = CW'(FAST_RISE);
        end else begin
          low_len_o  = CW'(STD_HALF);
          high_len_o = CW'(STD_HALF);
          rise_lim_o = CW'(STD_RISE);
        end
      end
    end else begin : g_std_only
      always_comb begin
        low_len_o  = CW'(STD_HALF);
        high_len_o = CW'(STD_HALF);
        rise_lim_o = CW'(STD_RISE);
      end
    end
  endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          scl_sense_i,
  input  logic [CW-1:0] low_len_i,
  input  logic [CW-1:0] high_len_i,
  input  logic [CW-1:0] rise_lim_i,
  output logic          pull_o,
  output logic          shift_stb_o,
  output logic          sample_stb_o,
  output logic          timeout_o
);
  scl_phase_e     ph_q;
  logic [CW-1:0]  cnt_q;
  logic           tmo_q;
  logic [CW-1:0]  mid_idx;

  assign mid_idx = high_len_i >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (!enable_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: begin
          if (cnt_q == low_len_i - CW'(1)) begin
            ph_q  <= PH_RISE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_RISE: begin
          if (scl_sense_i) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
          end else begin
            if (cnt_q == rise_lim_i) tmo_q <= 1'b1;
            if (cnt_q != rise_lim_i) cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_HIGH: begin
          if (cnt_q == high_len_i - CW'(1)) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign pull_o       = (ph_q == PH_LOW);
  assign shift_stb_o  = (ph_q == PH_LOW) && (cnt_q == '0);
  assign sample_stb_o = (ph_q == PH_HIGH) && (cnt_q == mid_idx);
  assign timeout_o    = tmo_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb_o && sample_stb_o)); // R8
  AST_SHIFT_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb_o |-> pull_o); // R8
  AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |-> !pull_o); // R5
  AST_RELEASE_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !pull_o && !timeout_o); // R9
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && enable_i |=> timeout_o); // R4
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int SYS_CLK_HZ = 8_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic fast_req_i,
  input  logic scl_sense_i,
  output logic scl_pull_o,
  output logic shift_stb_o,
  output logic sample_stb_o,
  output logic stretch_timeout_o,
  output logic fast_mode_o
);
  localparam int MHZ     = SYS_CLK_HZ / 1_000_000;
  localparam bit FAST_OK = (MHZ >= 4);
  localparam int MAXCNT  = SYS_CLK_HZ / 200_000 + MHZ + 2;
  localparam int CW      = $clog2(MAXCNT + 1);

  logic          fast_q;
  logic [CW-1:0] low_len, high_len, rise_lim;

  scl_mode_latch #(.FAST_OK(FAST_OK)) u_mode (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .fast_req_i(fast_req_i), .fast_q(fast_q)
  );

  scl_timing_sel #(.SYS_CLK_HZ(SYS_CLK_HZ), .CW(CW)) u_sel (
    .fast_i(fast_q), .low_len_o(low_len), .high_len_o(high_len),
    .rise_lim_o(rise_lim)
  );

  scl_phase_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .scl_sense_i(scl_sense_i),
    .low_len_i(low_len), .high_len_i(high_len), .rise_lim_i(rise_lim),
    .pull_o(scl_pull_o), .shift_stb_o(shift_stb_o),
    .sample_stb_o(sample_stb_o), .timeout_o(stretch_timeout_o)
  );

  assign fast_mode_o = fast_q;

  AST_NO_FAST_SLOWCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !FAST_OK |-> !fast_mode_o); // R7
endmodule

// File: tb/scl_clk_gen_tb_top.sv
module scl_clk_gen_tb_top;
  localparam int HZ      = 8_000_000;
  localparam int MHZ     = HZ / 1_000_000;
  localparam int STD_H   = HZ / 200_000;
  localparam int FU      = HZ / 1_200_000;
  localparam int STD_RL  = MHZ + 1;
  localparam int FAST_RL = 300 * MHZ / 1000 + 1;
  localparam int SLOW_HZ = 3_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, freq = 1'b0;
  logic pull, shs, sms, tmo, fm;
  logic scl_line;
  int   hold_left = 0;
  logic en_s = 1'b0;
  logic pull_s, shs_s, sms_s, tmo_s, fm_s;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign scl_line = !pull && (hold_left == 0);
  always @(posedge clk) if (!pull && hold_left > 0) hold_left <= hold_left - 1;

  scl_clk_gen #(.SYS_CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .fast_req_i(freq),
    .scl_sense_i(scl_line), .scl_pull_o(pull), .shift_stb_o(shs),
    .sample_stb_o(sms), .stretch_timeout_o(tmo), .fast_mode_o(fm)
  );

  scl_clk_gen #(.SYS_CLK_HZ(SLOW_HZ)) dut_slow (
    .clk(clk), .rst_n(rst_n), .enable_i(en_s), .fast_req_i(freq),
    .scl_sense_i(!pull_s), .scl_pull_o(pull_s), .shift_stb_o(shs_s),
    .sample_stb_o(sms_s), .stretch_timeout_o(tmo_s), .fast_mode_o(fm_s)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one SCL period starting at the next shift strobe.
  task automatic measure(output int low, output int rel, output int sidx,
                         output int nshift, output int nsample);
    low = 0; rel = 0; sidx = -1; nshift = 0; nsample = 0;
    while (!shs) @(negedge clk);
    do begin
      if (shs) nshift++;
      low++;
      @(negedge clk);
    end while (pull);
    while (!pull) begin
      if (sms) begin sidx = rel; nsample++; end
      rel++;
      @(negedge clk);
    end
  endtask

  task automatic set_off_mode(input logic f);
    @(negedge clk); en = 1'b0; freq = f;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pull", int'(pull), 0);
    chk("R1 fast_mode", int'(fm), 0);
    chk("R1 strobes", int'(shs | sms), 0);
    chk("R1 timeout", int'(tmo), 0);
  endtask

  task automatic t_std;
    int lo, rl, si, ns, nm;
    set_off_mode(1'b0);
    en = 1'b1;
    measure(lo, rl, si, ns, nm);
    measure(lo, rl, si, ns, nm);
    chk("R2 low len", lo, STD_H);
    chk("R2 released len", rl, 1 + STD_H);
    chk("R8 sample index std", si, 1 + STD_H / 2);
    chk("R8 shift count", ns, 1);
    chk("R8 sample count", nm, 1);
    chk("R4 no timeout", int'(tmo), 0);
  endtask

  task automatic t_locked;
    int lo, rl, si, ns, nm;
    @(negedge clk); freq = 1'b1;
    measure(lo, rl, si, ns, nm);
    chk("R6 mode held", int'(fm), 0);
    chk("R6 low len unchanged", lo, STD_H);
  endtask

  task automatic t_fast;
    int lo, rl, si, ns, nm;
    set_off_mode(1'b1);
    chk("R6 captured while off", int'(fm), 1);
    en = 1'b1;
    measure(lo, rl, si, ns, nm);
    chk("R3 low len", lo, 2 * FU);
    chk("R3 released len", rl, 1 + FU);
    chk("R8 sample index fast", si, 1 + FU / 2);
  endtask

  task automatic t_stretch_std;
    int lo, rl, si, ns, nm;
    set_off_mode(1'b0);
    en = 1'b1;
    while (!shs) @(negedge clk);
    hold_left = STD_RL;
    measure(lo, rl, si, ns, nm);
    chk("R5 stretched len", rl, STD_RL + 1 + STD_H);
    chk("R5 sample after stretch", si, STD_RL + 1 + STD_H / 2);
    chk("R4 at limit no timeout", int'(tmo), 0);
    while (!shs) @(negedge clk);
    hold_left = STD_RL + 1;
    measure(lo, rl, si, ns, nm);
    chk("R4 over limit timeout", int'(tmo), 1);
    measure(lo, rl, si, ns, nm);
    chk("R4 timeout sticky", int'(tmo), 1);
  endtask

  task automatic t_disable;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R9 released", int'(pull), 0);
    chk("R9 timeout cleared", int'(tmo), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 restart low", int'(pull), 1);
    chk("R9 restart shift", int'(shs), 1);
  endtask

  task automatic t_stretch_fast;
    int lo, rl, si, ns, nm;
    set_off_mode(1'b1);
    en = 1'b1;
    while (!shs) @(negedge clk);
    hold_left = FAST_RL;
    measure(lo, rl, si, ns, nm);
    chk("R4 fast at limit", int'(tmo), 0);
    while (!shs) @(negedge clk);
    hold_left = FAST_RL + 1;
    measure(lo, rl, si, ns, nm);
    chk("R4 fast over limit", int'(tmo), 1);
  endtask

  task automatic t_slow;
    int lo;
    @(negedge clk); en_s = 1'b0; freq = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 fallback mode", int'(fm_s), 0);
    en_s = 1'b1;
    while (!shs_s) @(negedge clk);
    lo = 0;
    while (pull_s) begin lo++; @(negedge clk); end
    chk("R7 fallback low len", lo, SLOW_HZ / 200_000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std();
        t_locked();
        t_fast();
        t_stretch_std();
        t_disable();
        t_stretch_fast();
        t_slow();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule